// File: doc/BRIEF.md
# Graphics Port Status-Bus Arbiter

This block sits on the target side of a graphics expansion port. Each cycle it decides what the attached bus master may do next. It announces that decision with a grant line and a 3-bit status code, and the code only has meaning while the grant is high. It has five candidate jobs:

- return read data that the master asked for earlier;
- collect write data for a write command that is already queued;
- let the master open a new transaction, either by queuing further requests or by running a conventional PCI-style cycle.

Each read or write job exists at a high and a low priority. Pending-work flags come from the surrounding request queues, and the request line comes from the master. A completion pulse from the data-phase logic ends a grant.

The control is a three-state machine:

- **IDLE**: nothing is granted. The code rests at 111.
- **HOLD**: a grant is out. Grant and code stay frozen.
- **GAP**: the single cycle with grant low that follows every completion.

The transitions are:

- **IDLE→HOLD** or **GAP→HOLD**, called *issue*: at least one job is present at the clock edge.
- **IDLE→IDLE** or **GAP→IDLE**, called *rest*: no job is present.
- **HOLD→GAP**, called *release*: the completion pulse is sampled.
- **HOLD→HOLD**, called *keep*: no completion pulse.

At issue, the winning job's code is captured in a register. That register drives the status bus for the whole of HOLD.

Top module: `gstat_arbiter`

## Requirements
- R1: While reset is active, and in the first cycle after it, gnt_o is 0 and st_o is 3'b111.
- R2: With no pending flag and no request, gnt_o stays 0 and st_o stays 3'b111 (rest transition).
- R3: The status codes are:
  - 3'b000: low-priority read return.
  - 3'b001: high-priority read return.
  - 3'b010: low-priority write-data demand.
  - 3'b011: high-priority write-data demand.
  - 3'b111: permission to start a new transaction, in answer to mst_req_i.
- R4: When several jobs are present at issue, the winner follows this order, from first to last:
  - high-priority read;
  - high-priority write;
  - low-priority read;
  - low-priority write;
  - transaction start.
- R5: When grant is low and a job is present at a rising clock edge, gnt_o is 1 with the matching code in the cycle after that edge.
- R6: During HOLD, gnt_o and st_o do not change until xfer_done_i is sampled high. Changes on the pending flags and on the request have no effect on them.
- R7: A sampled xfer_done_i during HOLD makes gnt_o 0 for exactly one cycle when work is still present. The next grant then carries the code chosen from the inputs seen in that low cycle.
- R8: xfer_done_i has no effect while gnt_o is 0.
- R9: st_o never takes the values 3'b100, 3'b101 or 3'b110.
- R10: Whenever gnt_o is 0, st_o is 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_req_i | input | 1 | Master asks to start a new transaction |
| rd_hi_pend_i | input | 1 | High-priority read data waiting to return |
| rd_lo_pend_i | input | 1 | Low-priority read data waiting to return |
| wr_hi_pend_i | input | 1 | High-priority queued write waiting for data |
| wr_lo_pend_i | input | 1 | Low-priority queued write waiting for data |
| xfer_done_i | input | 1 | Data phase finished; releases the grant |
| gnt_o | output | 1 | Grant; qualifies st_o |
| st_o | output | 3 | Status code for the master |

## Verification
The case hardest to reach from the ports is a completion that arrives while a different job, or a higher-priority job, is already waiting. Here the single GAP cycle must re-arbitrate on fresh inputs, and the code that was held must not leak into the next grant. Directed sequences set this up: they pulse completion while every flag is set, then swap the flags inside the low cycle. A long seeded random phase flips flags, the request and completion independently each cycle, so it also hits flag changes in the middle of HOLD and completions that arrive while nothing is granted.

// File: rtl/gstat_pkg.sv
package gstat_pkg;

    localparam int CODE_W = 3;
    localparam int N_SRC  = 5;
    localparam int FSM_W  = 2;

    typedef enum logic [CODE_W-1:0] {
        ST_RD_LO = 3'b000,
        ST_RD_HI = 3'b001,
        ST_WR_LO = 3'b010,
        ST_WR_HI = 3'b011,
        ST_START = 3'b111
    } stcode_e;

    typedef enum logic [FSM_W-1:0] {
        S_IDLE = 2'd0,
        S_HOLD = 2'd1,
        S_GAP  = 2'd2
    } fsm_e;

    // Slot index in the priority vector -> code; slot 0 wins.
    function automatic stcode_e code_of(input int slot);
        stcode_e c;
        case (slot)
            0:       c = ST_RD_HI;
            1:       c = ST_WR_HI;
            2:       c = ST_RD_LO;
            3:       c = ST_WR_LO;
            default: c = ST_START;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gstat_pick.sv
module gstat_pick
    import gstat_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic [N-1:0] pend,
    output logic         any,
    output stcode_e      code
);

    logic [N-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_hit
            if (i == 0) begin : g_first
                assign hit[i] = pend[i];
            end else begin : g_rest
                assign hit[i] = pend[i] & ~(|pend[i-1:0]);
            end
        end
    endgenerate

    assign any = |pend;

    always_comb begin
        code = ST_START;
        for (int k = 0; k < N; k++) begin
            if (hit[k]) code = code_of(k);
        end
    end

endmodule

// File: rtl/gstat_fsm.sv
module gstat_fsm
    import gstat_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    any,
    input  stcode_e pick,
    input  logic    done,
    output logic    gnt,
    output stcode_e st
);

    fsm_e    state_q, state_d;
    stcode_e code_q;

    // State register and captured code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            code_q  <= ST_START;
        end else begin
            state_q <= state_d;
            if (state_q != S_HOLD && any) code_q <= pick;
        end
    end

    // Transitions: issue, rest, keep, release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_GAP: state_d = any  ? S_HOLD : S_IDLE;
            S_HOLD:        state_d = done ? S_GAP  : S_HOLD;
            default:       state_d = S_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        gnt = 1'b0;
        st  = ST_START;
        unique case (state_q)
            S_HOLD: begin
                gnt = 1'b1;
                st  = code_q;
            end
            default: begin
                gnt = 1'b0;
                st  = ST_START;
            end
        endcase
    end

endmodule

// File: rtl/gstat_arbiter.sv
module gstat_arbiter
    import gstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_req_i,
    input  logic              rd_hi_pend_i,
    input  logic              rd_lo_pend_i,
    input  logic              wr_hi_pend_i,
    input  logic              wr_lo_pend_i,
    input  logic              xfer_done_i,
    output logic              gnt_o,
    output logic [CODE_W-1:0] st_o
);

    logic [N_SRC-1:0] pend;
    logic             any;
    stcode_e          pick;
    stcode_e          st;

    // Slot order is the priority order.
    assign pend = {mst_req_i, wr_lo_pend_i, rd_lo_pend_i, wr_hi_pend_i, rd_hi_pend_i};

    gstat_pick #(.N(N_SRC)) u_pick (
        .pend (pend),
        .any  (any),
        .code (pick)
    );

    gstat_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .any   (any),
        .pick  (pick),
        .done  (xfer_done_i),
        .gnt   (gnt_o),
        .st    (st)
    );

    assign st_o = st;

endmodule

// File: rtl/gstat_arbiter_chk.sv
module gstat_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mst_req_i,
    input logic       rd_hi_pend_i,
    input logic       rd_lo_pend_i,
    input logic       wr_hi_pend_i,
    input logic       wr_lo_pend_i,
    input logic       xfer_done_i,
    input logic       gnt_o,
    input logic [2:0] st_o
);

    logic work;
    assign work = mst_req_i | rd_hi_pend_i | rd_lo_pend_i | wr_hi_pend_i | wr_lo_pend_i;

    a_r9_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_o inside {3'b100, 3'b101, 3'b110}));

    a_r10_low_code: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_o |-> st_o == 3'b111);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_o && !xfer_done_i |=> gnt_o && $stable(st_o));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_o && xfer_done_i |=> !gnt_o);

    a_r5_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_o && work |=> gnt_o);

    a_r2_rest: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_o && !work |=> !gnt_o);

    a_r4_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_o && rd_hi_pend_i |=> st_o == 3'b001);

endmodule

bind gstat_arbiter gstat_arbiter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mst_req_i    (mst_req_i),
    .rd_hi_pend_i (rd_hi_pend_i),
    .rd_lo_pend_i (rd_lo_pend_i),
    .wr_hi_pend_i (wr_hi_pend_i),
    .wr_lo_pend_i (wr_lo_pend_i),
    .xfer_done_i  (xfer_done_i),
    .gnt_o        (gnt_o),
    .st_o         (st_o)
);

// File: tb/sim_gstat_arbiter.sv
`timescale 1ns/1ps
module sim_gstat_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 0, rdh = 0, rdl = 0, wrh = 0, wrl = 0, done = 0;
    logic       gnt;
    logic [2:0] st;

    int total = 0;
    int bad = 0;
    logic       m_gnt = 1'b0;
    logic [2:0] m_code = 3'b111;

    always #4 clk = ~clk;

    gstat_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .mst_req_i(req),
        .rd_hi_pend_i(rdh), .rd_lo_pend_i(rdl),
        .wr_hi_pend_i(wrh), .wr_lo_pend_i(wrl),
        .xfer_done_i(done), .gnt_o(gnt), .st_o(st)
    );

    function automatic logic [2:0] exp_pick(logic q, logic a, logic b, logic c, logic d);
        if (a)      return 3'b001; // R4: high read first
        else if (c) return 3'b011; // then high write
        else if (b) return 3'b000; // then low read
        else if (d) return 3'b010; // then low write
        else        return 3'b111; // then start (R3)
    endfunction

    task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: model follows inputs seen at the edge, compare at negedge.
    task automatic cyc(string tag);
        @(posedge clk);
        if (m_gnt) begin
            if (done) m_gnt = 1'b0;
        end else if (req | rdh | rdl | wrh | wrl) begin
            m_gnt  = 1'b1;
            m_code = exp_pick(req, rdh, rdl, wrh, wrl);
        end
        @(negedge clk);
        chk({tag, " gnt"}, {2'b0, gnt}, {2'b0, m_gnt});
        chk({tag, " st"}, st, m_gnt ? m_code : 3'b111);
        chk("R9 reserved", {2'b0, (st inside {3'b100, 3'b101, 3'b110})}, 3'b000);
    endtask

    task automatic setp(logic q, logic a, logic b, logic c, logic d, logic e);
        req = q; rdh = a; rdl = b; wrh = c; wrl = d; done = e;
    endtask

    // Single source: issue, then release.
    task automatic single(logic q, logic a, logic b, logic c, logic d, string tag);
        setp(q, a, b, c, d, 0);
        cyc({tag, " R5 R3"});
        setp(0, 0, 0, 0, 0, 1);
        cyc("R7 release");
        setp(0, 0, 0, 0, 0, 0);
        cyc("R2 after release");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        // R1: reset state
        @(negedge clk);
        chk("R1 gnt", {2'b0, gnt}, 3'b000);
        chk("R1 st", st, 3'b111);
        @(negedge clk);
        rst_n = 1'b1;
        cyc("R1 first cycle");
        cyc("R2 idle");
        cyc("R2 idle");

        // R8: completion while idle
        setp(0, 0, 0, 0, 0, 1);
        cyc("R8 done idle");
        cyc("R8 done idle");
        setp(0, 0, 0, 0, 0, 0);

        single(0, 0, 1, 0, 0, "rd_lo 000");
        single(0, 1, 0, 0, 0, "rd_hi 001");
        single(0, 0, 0, 0, 1, "wr_lo 010");
        single(0, 0, 0, 1, 0, "wr_hi 011");
        single(1, 0, 0, 0, 0, "req 111");

        // R4: pairs
        single(1, 1, 1, 1, 1, "R4 all");
        single(0, 0, 1, 1, 0, "R4 wrh>rdl");
        single(0, 0, 1, 0, 1, "R4 rdl>wrl");
        single(1, 0, 0, 0, 1, "R4 wrl>req");

        // R6: flags change during hold
        setp(0, 0, 0, 0, 1, 0);
        cyc("R6 issue");
        setp(1, 1, 1, 1, 1, 0);
        cyc("R6 hold");
        setp(0, 0, 0, 0, 0, 0);
        cyc("R6 hold");

        // R7: release with work waiting, swap inputs during gap
        setp(1, 1, 1, 1, 1, 1);
        cyc("R7 gap");
        setp(0, 0, 1, 0, 0, 0);
        cyc("R7 regrant");
        setp(0, 0, 0, 0, 0, 1);
        cyc("R7 release");
        setp(0, 0, 0, 0, 0, 0);
        cyc("R10 idle");

        // Seeded random phase
        for (int n = 0; n < 3000; n++) begin
            setp(($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 4) == 0,
                 ($urandom % 5) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0);
            cyc("R6 R7 R10 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule